// File: doc/BRIEF.md
# Ping-Pong Bounce Buffer Scanout

This block feeds a display pixel stream from two small on-chip line buffers that take turns. While the output side drains one bank through a valid/ready stream, an outside producer refills the other bank through a write port. The producer may be a software copy loop or a fill routine that makes pixels on the fly. When the output side has sent the last pixel of its bank, the banks change roles. The emptied bank is then offered to the producer through a request that carries the frame pixel position the bank must cover and its size in bytes.

Each bank holds a whole number of display lines. The fill position moves forward by one bank per refill and returns to zero at the end of the frame. After reset both banks are requested and filled before the stream starts. From then on the stream never stalls for lack of data. If the bank it needs is not yet full, it sends a fixed dummy pixel with a marker, leaves its read position where it is, and sets a sticky underrun flag. A narrow write mode widens 8-bit colour-index pixels to 16-bit pixels as they are stored.

Top module: `bb_scanout`

## Requirements
- R1: After reset, `req_valid` is 1 with `req_pos` 0 and `req_bank` 0, `pix_valid` is 0, `underrun` is 0, and `req_bytes` equals bank pixels times 2.
- R2: `pix_valid` stays 0 until both banks have been filled once. The second request after reset asks for position BUF_PX in bank 1.
- R3: A request keeps `req_valid`, `req_pos` and `req_bank` steady until the cycle `req_ack` is 1. After that acknowledge, the next BUF_PX cycles with `wr_en` high fill the requested bank in address order.
- R4: Each completed fill moves the fill position forward by BUF_PX. After the chunk that starts at FRAME_PX-BUF_PX, the position wraps to 0.
- R5: Pixels leave in the order they were written, one bank after the other, starting with bank 0. Once a bank has been drained, a refill request is raised for that bank.
- R6: While `pix_valid` is 1 and `pix_ready` is 0, `pix_data` holds its value and no pixel is consumed.
- R7: When the bank being read is not full, a transfer sends DUMMY_PIX (default 16'h0000) with `pix_dummy` set and does not move the read position.
- R8: `underrun` becomes 1 after any dummy transfer and stays 1 until `underrun_clr` is high at a clock edge with no dummy transfer in that cycle.
- R9: With `wr_narrow` high, the low byte c of `wr_data` is read as red c[7:5], green c[4:2], blue c[1:0]. It is stored as the pixel {c[7:5],c[7:6], c[4:2],c[4:2], c[1:0],c[1:0],c[1]}.
- R10: `wr_en` has no effect while no fill has been acknowledged, that is, while a request is still pending or the next bank is still full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | output | 1 | Refill request pending |
| req_ack | input | 1 | Producer accepts the pending request |
| req_pos | output | POS_W | Frame pixel position of the chunk to load |
| req_bytes | output | BYTES_W | Chunk length in bytes |
| req_bank | output | 1 | Bank that the request refills |
| wr_en | input | 1 | Producer pixel write strobe |
| wr_narrow | input | 1 | Widen the low byte of `wr_data` as an 8-bit colour index |
| wr_data | input | 16 | Producer pixel |
| pix_valid | output | 1 | Output stream has a beat |
| pix_ready | input | 1 | Display side takes the beat |
| pix_data | output | 16 | Output pixel |
| pix_dummy | output | 1 | Beat is filler caused by underrun |
| underrun | output | 1 | Sticky underrun indicator |
| underrun_clr | input | 1 | Clears `underrun` |

## Verification
The assertions assume that the producer raises `req_ack` only while `req_valid` is high. They also assume it writes exactly one bank's worth of pixels after each acknowledge and changes `wr_narrow` only between fills. The stimulus follows this. Every fill goes through one task that waits for the request, acknowledges it in a single cycle and then writes BUF_PX consecutive pixels. Stray writes are driven only while a request is still pending, which keeps the write count per fill exact.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int PIX_W = 16;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_REQ   = 2'd1,
        FS_WRITE = 2'd2
    } fill_st_e;

    typedef struct packed {
        logic dummy;
        pix_t data;
    } beat_t;

    // 3:3:2 colour index widened to 5:6:5 by repeating the top bits
    function automatic pix_t expand332(input logic [7:0] c);
        return {c[7:5], c[7:6], c[4:2], c[4:2], c[1:0], c[1:0], c[1]};
    endfunction
endpackage

// File: rtl/bb_fill_ctrl.sv
module bb_fill_ctrl
    import bb_pkg::*;
#(
    parameter int BUF_PX   = 16,
    parameter int FRAME_PX = 48,
    localparam int IDX_W   = $clog2(BUF_PX),
    localparam int POS_W   = $clog2(FRAME_PX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bank_full,
    input  logic             req_ack,
    input  logic             wr_en,
    input  logic             wr_narrow,
    input  pix_t             wr_data,
    output logic             req_valid,
    output logic [POS_W-1:0] req_pos,
    output logic             fill_bank,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_idx,
    output pix_t             mem_wdata,
    output logic             fill_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BUF_PX - 1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_PX - BUF_PX);
    localparam logic [POS_W-1:0] STEP     = POS_W'(BUF_PX);

    fill_st_e         state;
    logic             bank;
    logic [POS_W-1:0] pos;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_REQ;
            bank  <= 1'b0;
            pos   <= '0;
            idx   <= '0;
        end else begin
            case (state)
                FS_IDLE:  if (!bank_full[bank]) state <= FS_REQ;
                FS_REQ: begin
                    if (req_ack) begin
                        state <= FS_WRITE;
                        idx   <= '0;
                    end
                end
                FS_WRITE: begin
                    if (wr_en) begin
                        if (idx == LAST_IDX) begin
                            state <= FS_IDLE;
                            bank  <= ~bank;
                            pos   <= (pos == LAST_POS) ? '0 : pos + STEP;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    assign req_valid = (state == FS_REQ);
    assign req_pos   = pos;
    assign fill_bank = bank;
    assign mem_we    = (state == FS_WRITE) && wr_en;
    assign mem_idx   = idx;
    assign mem_wdata = wr_narrow ? expand332(wr_data[7:0]) : wr_data;
    assign fill_done = mem_we && (idx == LAST_IDX);
endmodule

// File: rtl/bb_bank_store.sv
module bb_bank_store
    import bb_pkg::*;
#(
    parameter int BUF_PX = 16,
    localparam int IDX_W = $clog2(BUF_PX)
) (
    input  logic             clk,
    input  logic             we,
    input  logic             wbank,
    input  logic [IDX_W-1:0] widx,
    input  pix_t             wdata,
    input  logic             rbank,
    input  logic [IDX_W-1:0] ridx,
    output pix_t             rdata
);
    pix_t rd_b [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        pix_t mem [BUF_PX];
        always_ff @(posedge clk) begin
            if (we && (wbank == 1'(b))) mem[widx] <= wdata;
        end
        assign rd_b[b] = mem[ridx];
    end

    assign rdata = rd_b[rbank];
endmodule

// File: rtl/bb_scan_out.sv
module bb_scan_out
    import bb_pkg::*;
#(
    parameter int   BUF_PX    = 16,
    parameter pix_t DUMMY_PIX = '0,
    localparam int  IDX_W     = $clog2(BUF_PX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bank_full,
    input  pix_t             rdata,
    input  logic             pix_ready,
    input  logic             underrun_clr,
    output logic             rbank,
    output logic [IDX_W-1:0] ridx,
    output logic             pix_valid,
    output beat_t            beat,
    output logic             underrun,
    output logic             drain_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BUF_PX - 1);

    logic started;
    logic live;
    logic xfer;

    assign live       = bank_full[rbank];
    assign pix_valid  = started;
    assign xfer       = started && pix_ready;
    assign drain_done = xfer && live && (ridx == LAST_IDX);

    always_comb begin
        beat.dummy = started && !live;
        beat.data  = live ? rdata : DUMMY_PIX;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started  <= 1'b0;
            rbank    <= 1'b0;
            ridx     <= '0;
            underrun <= 1'b0;
        end else begin
            if (&bank_full) started <= 1'b1;
            if (xfer && live) begin
                if (ridx == LAST_IDX) begin
                    ridx  <= '0;
                    rbank <= ~rbank;
                end else begin
                    ridx <= ridx + 1'b1;
                end
            end
            if (xfer && !live)     underrun <= 1'b1;
            else if (underrun_clr) underrun <= 1'b0;
        end
    end
endmodule

// File: rtl/bb_scanout.sv
module bb_scanout
    import bb_pkg::*;
#(
    parameter int   LINE_PX     = 8,
    parameter int   BUF_LINES   = 2,
    parameter int   FRAME_LINES = 6,   // whole multiple of BUF_LINES
    parameter pix_t DUMMY_PIX   = '0,
    localparam int  BUF_PX      = LINE_PX * BUF_LINES,
    localparam int  FRAME_PX    = LINE_PX * FRAME_LINES,
    localparam int  BUF_BYTES   = BUF_PX * PIX_W / 8,
    localparam int  IDX_W       = $clog2(BUF_PX),
    localparam int  POS_W       = $clog2(FRAME_PX),
    localparam int  BYTES_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    output logic               req_valid,
    input  logic               req_ack,
    output logic [POS_W-1:0]   req_pos,
    output logic [BYTES_W-1:0] req_bytes,
    output logic               req_bank,
    input  logic               wr_en,
    input  logic               wr_narrow,
    input  logic [15:0]        wr_data,
    output logic               pix_valid,
    input  logic               pix_ready,
    output logic [15:0]        pix_data,
    output logic               pix_dummy,
    output logic               underrun,
    input  logic               underrun_clr
);
    logic [1:0]       bank_full;
    logic             fill_bank, mem_we, fill_done;
    logic [IDX_W-1:0] mem_idx, ridx;
    pix_t             mem_wdata, rdata;
    logic             rbank, drain_done;
    beat_t            beat;

    bb_fill_ctrl #(.BUF_PX(BUF_PX), .FRAME_PX(FRAME_PX)) fill_i (
        .clk(clk), .rst(rst), .bank_full(bank_full), .req_ack(req_ack),
        .wr_en(wr_en), .wr_narrow(wr_narrow), .wr_data(wr_data),
        .req_valid(req_valid), .req_pos(req_pos), .fill_bank(fill_bank),
        .mem_we(mem_we), .mem_idx(mem_idx), .mem_wdata(mem_wdata),
        .fill_done(fill_done)
    );

    bb_bank_store #(.BUF_PX(BUF_PX)) store_i (
        .clk(clk), .we(mem_we), .wbank(fill_bank), .widx(mem_idx),
        .wdata(mem_wdata), .rbank(rbank), .ridx(ridx), .rdata(rdata)
    );

    bb_scan_out #(.BUF_PX(BUF_PX), .DUMMY_PIX(DUMMY_PIX)) scan_i (
        .clk(clk), .rst(rst), .bank_full(bank_full), .rdata(rdata),
        .pix_ready(pix_ready), .underrun_clr(underrun_clr),
        .rbank(rbank), .ridx(ridx), .pix_valid(pix_valid), .beat(beat),
        .underrun(underrun), .drain_done(drain_done)
    );

    // a bank is filled only while empty and drained only while full,
    // so the two events never meet on the same bank
    for (genvar b = 0; b < 2; b++) begin : g_full
        always_ff @(posedge clk) begin
            if (rst)                                   bank_full[b] <= 1'b0;
            else if (fill_done && fill_bank == 1'(b))  bank_full[b] <= 1'b1;
            else if (drain_done && rbank == 1'(b))     bank_full[b] <= 1'b0;
        end
    end

    assign req_bank  = fill_bank;
    assign req_bytes = BYTES_W'(BUF_BYTES);
    assign pix_data  = beat.data;
    assign pix_dummy = beat.dummy;
endmodule

// File: rtl/bb_scanout_chk.sv
module bb_scanout_chk #(
    parameter int          FRAME_PX  = 48,
    parameter int          BUF_PX    = 16,
    parameter logic [15:0] DUMMY_PIX = '0,
    parameter int          POS_W     = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ack,
    input logic [POS_W-1:0] req_pos,
    input logic             req_bank,
    input logic             pix_valid,
    input logic             pix_ready,
    input logic [15:0]      pix_data,
    input logic             pix_dummy,
    input logic             underrun,
    input logic             underrun_clr
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ack |=> req_valid && $stable(req_pos) && $stable(req_bank)) // R3
        else $error("request dropped or changed before acknowledge");

    AST_POS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (int'(req_pos) < FRAME_PX) && (int'(req_pos) % BUF_PX == 0)) // R4
        else $error("request position outside frame or misaligned");

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
        pix_valid && !pix_ready && !pix_dummy |=> pix_valid && $stable(pix_data)) // R6
        else $error("beat changed while stalled");

    AST_DUMMY_VALUE: assert property (@(posedge clk) disable iff (rst)
        pix_dummy |-> pix_valid && pix_data == DUMMY_PIX) // R7
        else $error("filler beat carries wrong value");

    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        pix_valid && pix_ready && pix_dummy |=> underrun) // R8
        else $error("underrun not flagged");

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        underrun && !underrun_clr |=> underrun) // R8
        else $error("underrun cleared without request");
endmodule

bind bb_scanout bb_scanout_chk #(
    .FRAME_PX(FRAME_PX), .BUF_PX(BUF_PX), .DUMMY_PIX(DUMMY_PIX), .POS_W(POS_W)
) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ack(req_ack),
    .req_pos(req_pos), .req_bank(req_bank), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .pix_dummy(pix_dummy),
    .underrun(underrun), .underrun_clr(underrun_clr)
);

// File: tb/bb_scanout_tb_top.sv
module bb_scanout_tb_top;
    localparam int BUF_PX   = 16;
    localparam int FRAME_PX = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid, req_ack = 1'b0, req_bank;
    logic [5:0]  req_pos;
    logic [5:0]  req_bytes;
    logic        wr_en = 1'b0, wr_narrow = 1'b0;
    logic [15:0] wr_data = '0;
    logic        pix_valid, pix_ready = 1'b0, pix_dummy, underrun;
    logic [15:0] pix_data;
    logic        underrun_clr = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    bb_scanout dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ack(req_ack),
        .req_pos(req_pos), .req_bytes(req_bytes), .req_bank(req_bank),
        .wr_en(wr_en), .wr_narrow(wr_narrow), .wr_data(wr_data),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .pix_dummy(pix_dummy), .underrun(underrun), .underrun_clr(underrun_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] widen(input logic [7:0] c);
        logic [2:0] r = c[7:5];
        logic [2:0] g = c[4:2];
        logic [1:0] b = c[1:0];
        return {r, r[2:1], g, g, b, b, b[1]};
    endfunction

    function automatic logic [15:0] pat(input int base, input int i, input bit narrow);
        return narrow ? widen(8'(i * 37 + base)) : 16'(base + i);
    endfunction

    // waits for a request, checks it, acks, writes one bank
    task automatic fill(input int pos, input int bank, input int base, input bit narrow,
                        input bit stray);
        int n = 0;
        while (!req_valid && n < 200) begin @(negedge clk); n++; end
        chk(req_valid, "R5 refill request raised", req_valid, 1);
        chk(req_pos == 6'(pos), "R4 request position", req_pos, pos);
        chk(req_bank == 1'(bank), "R5 request bank", req_bank, bank);
        if (stray) begin
            for (int k = 0; k < 3; k++) begin  // R10: ignored, no ack yet
                wr_en = 1'b1; wr_data = 16'hDEAD;
                @(negedge clk);
            end
            wr_en = 1'b0;
            chk(req_valid && req_pos == 6'(pos), "R3 request held", req_pos, pos);
        end
        req_ack = 1'b1;
        @(negedge clk);
        req_ack = 1'b0;
        wr_narrow = narrow;
        for (int i = 0; i < BUF_PX; i++) begin
            wr_en = 1'b1;
            wr_data = narrow ? {8'hA5, 8'(i * 37 + base)} : 16'(base + i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        wr_narrow = 1'b0;
    endtask

    task automatic drain(input int base, input bit narrow, input string req);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        pix_ready = 1'b1;
        for (int i = 0; i < BUF_PX; i++) begin
            if (!(pix_valid && !pix_dummy && pix_data == pat(base, i, narrow)) && bad == 0) begin
                first_act = pix_data; first_exp = pat(base, i, narrow);
            end
            if (!(pix_valid && !pix_dummy && pix_data == pat(base, i, narrow))) bad++;
            @(negedge clk);
        end
        pix_ready = 1'b0;
        chk(bad == 0, req, first_act, first_exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_valid == 1'b1, "R1 request after reset", req_valid, 1);
        chk(req_pos == 0 && req_bank == 0, "R1 first position", req_pos, 0);
        chk(pix_valid == 1'b0, "R1 stream idle", pix_valid, 0);
        chk(underrun == 1'b0, "R1 underrun clear", underrun, 0);
        chk(req_bytes == 6'(BUF_PX * 2), "R1 byte length", req_bytes, BUF_PX * 2);
    endtask

    task automatic t_startup;
        fill(0, 0, 16'h1000, 1'b0, 1'b1);
        @(negedge clk);
        chk(pix_valid == 1'b0, "R2 no output with one bank", pix_valid, 0);
        fill(BUF_PX, 1, 16'h2000, 1'b0, 1'b0);
        @(negedge clk);
        chk(pix_valid == 1'b1, "R2 output starts", pix_valid, 1);
        chk(pix_data == 16'h1000, "R2 first pixel", pix_data, 16'h1000);
    endtask

    task automatic t_stall;
        pix_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(pix_valid && pix_data == 16'h1000, "R6 data held", pix_data, 16'h1000);
    endtask

    task automatic t_stream;
        drain(16'h1000, 1'b0, "R5 bank0 order");
        fill(2 * BUF_PX, 0, 8'h11, 1'b1, 1'b0);
        drain(16'h2000, 1'b0, "R5 bank1 order");
        drain(8'h11, 1'b1, "R9 widened pixels");
    endtask

    task automatic t_underrun;
        int n = 0;
        while (!req_valid && n < 50) begin @(negedge clk); n++; end
        chk(req_pos == 0 && req_bank == 1, "R4 wrap to zero", req_pos, 0);
        pix_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
            chk(pix_valid && pix_dummy && pix_data == 16'h0000, "R7 filler beat", pix_data, 0);
            @(negedge clk);
        end
        pix_ready = 1'b0;
        repeat (2) @(negedge clk);
        chk(underrun == 1'b1, "R8 sticky underrun", underrun, 1);
        underrun_clr = 1'b1;
        @(negedge clk);
        underrun_clr = 1'b0;
        chk(underrun == 1'b0, "R8 underrun cleared", underrun, 0);
        fill(0, 1, 16'h3000, 1'b0, 1'b1);
        @(negedge clk);
        chk(!pix_dummy, "R7 real data after refill", pix_dummy, 0);
        drain(16'h3000, 1'b0, "R7 read position kept (R10 stray writes dropped)");
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_startup();
        t_stall();
        t_stream();
        t_underrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule